// File: doc/BRIEF.md
# Prioritised Interrupt Distributor

This block collects raw interrupt request lines from peripherals and decides, for every processor core, which single request that core should service next. Each source is latched as pending either from a rising edge (sticky until serviced) or directly from the line level (pending only while the line is high). A source can reach a core only when the distributor is switched on, the source is enabled, the source's target mask names that core, and the source is not already being serviced. Among all such sources the block offers the one with the smallest priority number, and on a tie the one with the smaller ID.

Software configures the block through a word-wide register port with byte enables. Enables are changed through separate write-one-to-set and write-one-to-clear words. Priorities and target masks are packed four IDs per word, one byte each. Trigger modes are packed sixteen IDs per word, two bits each. The lowest `NUM_PRIV` IDs are private: each is wired to one fixed core and its target byte cannot be changed. The CPU-interface side sees an offer (valid, ID, priority) per core. An acknowledge pulse makes the offered source active. An end-of-service pulse that carries an ID retires it.

Top module: `irqd_top`

## Requirements
- R1: Bit 0 of the control word at offset 0x000 switches the distributor on; while it is 0 no core has a valid offer.
- R2: A set-enable word at 0x100 + 4*(N/32) enables ID N when a 1 is written to bit N mod 32; writing 0 there changes nothing; reading this word returns the current enables.
- R3: A clear-enable word at 0x180 + 4*(N/32) disables ID N when a 1 is written to bit N mod 32; writing 0 changes nothing; reading it also returns the current enables.
- R4: The priority byte of ID N is byte lane N mod 4 of the word at 0x400 + 4*(N/4), written only when its byte enable is set; every priority resets to 0x00, and a smaller value is more urgent.
- R5: The target byte of shared ID N (N >= 32) is byte lane N mod 4 of the word at 0x800 + 4*(N/4); bit k selects core k, only bits 0 and 1 are stored, and the rest read as 0.
- R6: Private IDs 0..15 always target core 0 and IDs 16..31 always target core 1 (target byte 0x01 or 0x02); writes to their target bytes are ignored.
- R7: In the word at 0xC00 + 4*(N/16), bit 2*(N mod 16)+1 selects edge trigger (1) or level trigger (0) for ID N; the even bits are not stored and read as 0.
- R8: A level-triggered source is pending exactly while its sampled line is high, so a request withdrawn before acknowledge stops being offered.
- R9: An edge-triggered source becomes pending on a sampled 0-to-1 change of its line and stays pending after the line falls, until a core acknowledges it.
- R10: Each core is offered the eligible source with the smallest priority value, ties going to the smaller ID, together with that source's priority.
- R11: Acknowledging a valid offer makes that source active; an active source is not offered to any core until an end-of-service with its ID arrives, after which a still-pending source is offered again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_SRC | Raw request lines, bit N is ID N |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte offset of the word accessed (read and write) |
| reg_be | input | 4 | Byte enables of the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the word at reg_addr, combinational |
| offer_valid | output | NUM_CORE | A source is offered to core c |
| offer_id | output | NUM_CORE x ID_W | Offered ID per core |
| offer_prio | output | NUM_CORE x 8 | Priority of the offered ID per core |
| ack | input | NUM_CORE | Core c takes its current offer |
| eoi | input | NUM_CORE | Core c finishes servicing eoi_id |
| eoi_id | input | NUM_CORE x ID_W | ID retired by the end-of-service of core c |

## Verification
A change on a request line is sampled at the next rising edge and the offer reflects it right after that edge, one cycle later; register writes, acknowledges and end-of-service pulses likewise show in the offers one edge after they are presented, while register reads answer combinationally in the same cycle. The bench drives every input just after a falling edge, advances its reference model by exactly one edge per clock, and compares all offers at the following falling edge, so each comparison lands in the first cycle the result is due. Random line activity, random acknowledges and retirements and random register writes run against that model, next to directed sequences for each trigger mode, tie-breaks, private routing and the global switch.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

    localparam int REG_AW = 12;
    localparam int PRIO_W = 8;

    localparam logic [REG_AW-1:0] OFS_CTRL  = 12'h000;
    localparam logic [REG_AW-1:0] OFS_SETEN = 12'h100;
    localparam logic [REG_AW-1:0] OFS_CLREN = 12'h180;
    localparam logic [REG_AW-1:0] OFS_PRIO  = 12'h400;
    localparam logic [REG_AW-1:0] OFS_TGT   = 12'h800;
    localparam logic [REG_AW-1:0] OFS_CFG   = 12'hC00;

    typedef struct packed {
        logic              wr;
        logic [REG_AW-1:0] addr;
        logic [3:0]        be;
        logic [31:0]       data;
    } reg_req_t;

    function automatic logic word_hit(logic [REG_AW-1:0] a, logic [REG_AW-1:0] base, int word);
        return a == (base + REG_AW'(word * 4));
    endfunction

    function automatic logic [31:0] lane_mask(logic [3:0] be);
        logic [31:0] m;
        for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{be[i]}};
        return m;
    endfunction

endpackage

// File: rtl/irqd_regs.sv
module irqd_regs
    import irqd_pkg::*;
#(
    parameter int NUM_SRC  = 64,
    parameter int NUM_CORE = 2,
    parameter int NUM_PRIV = 32
) (
    input  logic                             clk,
    input  logic                             rst,
    input  reg_req_t                         req,
    input  logic [REG_AW-1:0]                rd_addr,
    output logic                             dist_en,
    output logic [NUM_SRC-1:0]               src_en,
    output logic [NUM_SRC-1:0][PRIO_W-1:0]   prio,
    output logic [NUM_SRC-1:0][NUM_CORE-1:0] tgt,
    output logic [NUM_SRC-1:0]               edge_cfg,
    output logic [31:0]                      rdata
);
    localparam int PRIV_PER_CORE = NUM_PRIV / NUM_CORE;

    logic [31:0] wbits;
    assign wbits = req.data & lane_mask(req.be);

    always_ff @(posedge clk) begin
        if (rst)
            dist_en <= 1'b0;
        else if (req.wr && word_hit(req.addr, OFS_CTRL, 0) && req.be[0])
            dist_en <= req.data[0];
    end

    for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
        localparam int EW = n / 32;
        localparam int EB = n % 32;
        localparam int BW = n / 4;
        localparam int BL = n % 4;
        localparam int CW = n / 16;
        localparam int CB = 2 * (n % 16) + 1;

        logic              en_q;
        logic              edge_q;
        logic [PRIO_W-1:0] prio_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                en_q   <= 1'b0;
                edge_q <= 1'b0;
                prio_q <= '0;
            end else if (req.wr) begin
                if (word_hit(req.addr, OFS_SETEN, EW) && wbits[EB])
                    en_q <= 1'b1;
                else if (word_hit(req.addr, OFS_CLREN, EW) && wbits[EB])
                    en_q <= 1'b0;
                if (word_hit(req.addr, OFS_PRIO, BW) && req.be[BL])
                    prio_q <= req.data[8*BL +: PRIO_W];
                if (word_hit(req.addr, OFS_CFG, CW) && req.be[CB/8])
                    edge_q <= req.data[CB];
            end
        end

        assign src_en[n]   = en_q;
        assign edge_cfg[n] = edge_q;
        assign prio[n]     = prio_q;

        if (n < NUM_PRIV) begin : g_priv
            assign tgt[n] = NUM_CORE'(1) << (n / PRIV_PER_CORE);
        end else begin : g_shared
            logic [NUM_CORE-1:0] tgt_q;
            always_ff @(posedge clk) begin
                if (rst)
                    tgt_q <= '0;
                else if (req.wr && word_hit(req.addr, OFS_TGT, BW) && req.be[BL])
                    tgt_q <= req.data[8*BL +: NUM_CORE];
            end
            assign tgt[n] = tgt_q;
        end
    end

    always_comb begin
        rdata = '0;
        if (word_hit(rd_addr, OFS_CTRL, 0)) rdata[0] = dist_en;
        for (int n = 0; n < NUM_SRC; n++) begin
            if (word_hit(rd_addr, OFS_SETEN, n / 32) || word_hit(rd_addr, OFS_CLREN, n / 32))
                rdata[n % 32] = src_en[n];
            if (word_hit(rd_addr, OFS_PRIO, n / 4))
                rdata[8*(n % 4) +: PRIO_W] = prio[n];
            if (word_hit(rd_addr, OFS_TGT, n / 4))
                rdata[8*(n % 4) +: NUM_CORE] = tgt[n];
            if (word_hit(rd_addr, OFS_CFG, n / 16))
                rdata[2*(n % 16) + 1] = edge_cfg[n];
        end
    end

    // R2 / R3: a write of all zeros to an enable word leaves the enables alone
    a_r2_zero_set_noop: assert property (@(posedge clk) disable iff (rst)
        (req.wr && word_hit(req.addr, OFS_SETEN, 0) && req.data == '0) |=> (src_en == $past(src_en)));
    a_r3_zero_clr_noop: assert property (@(posedge clk) disable iff (rst)
        (req.wr && word_hit(req.addr, OFS_CLREN, 0) && req.data == '0) |=> (src_en == $past(src_en)));

endmodule

// File: rtl/irqd_src.sv
module irqd_src #(
    parameter int NUM_SRC = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic [NUM_SRC-1:0] edge_cfg,
    input  logic [NUM_SRC-1:0] ack_clr,
    input  logic [NUM_SRC-1:0] eoi_clr,
    output logic [NUM_SRC-1:0] pend,
    output logic [NUM_SRC-1:0] act
);
    logic [NUM_SRC-1:0] line_q;
    logic [NUM_SRC-1:0] edge_pend_q;
    logic [NUM_SRC-1:0] rise;

    assign rise = irq_in & ~line_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q      <= '0;
            edge_pend_q <= '0;
            act         <= '0;
        end else begin
            line_q      <= irq_in;
            edge_pend_q <= edge_cfg & ((edge_pend_q & ~ack_clr) | rise);
            act         <= (act & ~eoi_clr) | ack_clr;
        end
    end

    // level sources follow the sampled line, edge sources the sticky latch
    assign pend = (edge_cfg & edge_pend_q) | (~edge_cfg & line_q);

    // R9: an edge-mode pending bit survives until acknowledged
    a_r9_edge_sticky: assert property (@(posedge clk) disable iff (rst)
        ((pend & edge_cfg) & $past(pend & edge_cfg & ~ack_clr)) == ($past(pend & edge_cfg & ~ack_clr) & edge_cfg));

endmodule

// File: rtl/irqd_arb.sv
module irqd_arb
    import irqd_pkg::*;
#(
    parameter int NUM_SRC = 64,
    localparam int ID_W   = $clog2(NUM_SRC)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NUM_SRC-1:0]             elig,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
    output logic                           valid,
    output logic [ID_W-1:0]                id,
    output logic [PRIO_W-1:0]              prio_o
);
    always_comb begin
        valid  = 1'b0;
        id     = '0;
        prio_o = '1;
        // strict compare keeps the earlier (smaller) ID on a tie
        for (int n = 0; n < NUM_SRC; n++) begin
            if (elig[n] && (!valid || prio[n] < prio_o)) begin
                valid  = 1'b1;
                id     = ID_W'(n);
                prio_o = prio[n];
            end
        end
    end

    // R10: whatever is offered must be one of the eligible sources
    a_r10_offer_eligible: assert property (@(posedge clk) disable iff (rst)
        valid |-> elig[id]);
    a_r10_idle_when_none: assert property (@(posedge clk) disable iff (rst)
        (elig == '0) |-> !valid);

endmodule

// File: rtl/irqd_top.sv
module irqd_top
    import irqd_pkg::*;
#(
    parameter int NUM_SRC  = 64,
    parameter int NUM_CORE = 2,
    parameter int NUM_PRIV = 32,
    localparam int ID_W    = $clog2(NUM_SRC)
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [NUM_SRC-1:0]               irq_in,
    input  logic                             reg_wr,
    input  logic [REG_AW-1:0]                reg_addr,
    input  logic [3:0]                       reg_be,
    input  logic [31:0]                      reg_wdata,
    output logic [31:0]                      reg_rdata,
    output logic [NUM_CORE-1:0]              offer_valid,
    output logic [NUM_CORE-1:0][ID_W-1:0]    offer_id,
    output logic [NUM_CORE-1:0][PRIO_W-1:0]  offer_prio,
    input  logic [NUM_CORE-1:0]              ack,
    input  logic [NUM_CORE-1:0]              eoi,
    input  logic [NUM_CORE-1:0][ID_W-1:0]    eoi_id
);
    reg_req_t                         req;
    logic                             dist_en;
    logic [NUM_SRC-1:0]               src_en;
    logic [NUM_SRC-1:0][PRIO_W-1:0]   prio;
    logic [NUM_SRC-1:0][NUM_CORE-1:0] tgt;
    logic [NUM_SRC-1:0]               edge_cfg;
    logic [NUM_SRC-1:0]               pend;
    logic [NUM_SRC-1:0]               act;
    logic [NUM_SRC-1:0]               ack_clr;
    logic [NUM_SRC-1:0]               eoi_clr;

    assign req = '{wr: reg_wr, addr: reg_addr, be: reg_be, data: reg_wdata};

    irqd_regs #(.NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE), .NUM_PRIV(NUM_PRIV)) regs_i (
        .clk(clk), .rst(rst), .req(req), .rd_addr(reg_addr),
        .dist_en(dist_en), .src_en(src_en), .prio(prio), .tgt(tgt),
        .edge_cfg(edge_cfg), .rdata(reg_rdata)
    );

    irqd_src #(.NUM_SRC(NUM_SRC)) src_i (
        .clk(clk), .rst(rst), .irq_in(irq_in), .edge_cfg(edge_cfg),
        .ack_clr(ack_clr), .eoi_clr(eoi_clr), .pend(pend), .act(act)
    );

    always_comb begin
        ack_clr = '0;
        eoi_clr = '0;
        for (int c = 0; c < NUM_CORE; c++) begin
            if (ack[c] && offer_valid[c]) ack_clr[offer_id[c]] = 1'b1;
            if (eoi[c] && int'(eoi_id[c]) < NUM_SRC) eoi_clr[eoi_id[c]] = 1'b1;
        end
    end

    for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
        logic [NUM_SRC-1:0] elig;

        always_comb begin
            for (int n = 0; n < NUM_SRC; n++)
                elig[n] = dist_en && src_en[n] && pend[n] && !act[n] && tgt[n][c];
        end

        irqd_arb #(.NUM_SRC(NUM_SRC)) arb_i (
            .clk(clk), .rst(rst), .elig(elig), .prio(prio),
            .valid(offer_valid[c]), .id(offer_id[c]), .prio_o(offer_prio[c])
        );

        // R11: an acknowledged offer is active on the next cycle
        a_r11_ack_sets_active: assert property (@(posedge clk) disable iff (rst)
            (ack[c] && offer_valid[c]) |=> act[$past(offer_id[c])]);
        // R11: an active source is never offered
        a_r11_active_not_offered: assert property (@(posedge clk) disable iff (rst)
            offer_valid[c] |-> !act[offer_id[c]]);
    end

    // R1: a switched-off distributor offers nothing
    a_r1_off_silent: assert property (@(posedge clk) disable iff (rst)
        !dist_en |-> (offer_valid == '0));

endmodule

// File: tb/irqd_top_tb.sv
module irqd_top_tb_top;
    localparam int NS = 64;
    localparam int NC = 2;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [NS-1:0]      irq = '0;
    logic               reg_wr = 1'b0;
    logic [11:0]        reg_addr = '0;
    logic [3:0]         reg_be = '0;
    logic [31:0]        reg_wdata = '0;
    logic [31:0]        reg_rdata;
    logic [NC-1:0]      offer_valid;
    logic [NC-1:0][5:0] offer_id;
    logic [NC-1:0][7:0] offer_prio;
    logic [NC-1:0]      ack = '0;
    logic [NC-1:0]      eoi = '0;
    logic [NC-1:0][5:0] eoi_id = '0;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    irqd_top dut_i (
        .clk(clk), .rst(rst), .irq_in(irq), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .offer_valid(offer_valid), .offer_id(offer_id), .offer_prio(offer_prio),
        .ack(ack), .eoi(eoi), .eoi_id(eoi_id)
    );

    // reference model
    bit       m_den;
    bit       m_en[NS];
    bit [7:0] m_prio[NS];
    bit [1:0] m_tgt[NS];
    bit       m_edge[NS];
    bit       m_pe[NS];
    bit       m_q[NS];
    bit       m_act[NS];

    function automatic bit [1:0] tgt_of(int n);
        if (n < 16) return 2'b01;
        if (n < 32) return 2'b10;
        return m_tgt[n];
    endfunction

    function automatic void exp_offer(int c, output bit v, output int id, output int p);
        v = 0; id = 0; p = 255;
        for (int n = 0; n < NS; n++) begin
            bit pd;
            pd = m_edge[n] ? m_pe[n] : m_q[n];
            if (m_den && m_en[n] && pd && !m_act[n] && tgt_of(n)[c] && (!v || m_prio[n] < p)) begin
                v = 1; id = n; p = m_prio[n];
            end
        end
    endfunction

    function automatic bit [31:0] mrd(bit [11:0] a);
        bit [31:0] r = 0;
        if (a == 12'h000) r[0] = m_den;
        for (int n = 0; n < NS; n++) begin
            if (a == 12'h100 + 4*(n/32) || a == 12'h180 + 4*(n/32)) r[n%32] = m_en[n];
            if (a == 12'h400 + 4*(n/4)) r[8*(n%4) +: 8] = m_prio[n];
            if (a == 12'h800 + 4*(n/4)) r[8*(n%4) +: 2] = tgt_of(n);
            if (a == 12'hC00 + 4*(n/16)) r[2*(n%16)+1] = m_edge[n];
        end
        return r;
    endfunction

    task automatic model_next();
        bit v; int id; int p;
        bit ac[NS]; bit ec[NS];
        for (int n = 0; n < NS; n++) begin ac[n] = 0; ec[n] = 0; end
        for (int c = 0; c < NC; c++) begin
            exp_offer(c, v, id, p);
            if (ack[c] && v) ac[id] = 1;
            if (eoi[c]) ec[eoi_id[c]] = 1;
        end
        for (int n = 0; n < NS; n++) begin
            m_pe[n]  = m_edge[n] & ((m_pe[n] & ~ac[n]) | (irq[n] & ~m_q[n]));
            m_q[n]   = irq[n];
            m_act[n] = (m_act[n] & ~ec[n]) | ac[n];
        end
        if (reg_wr) begin
            if (reg_addr == 12'h000 && reg_be[0]) m_den = reg_wdata[0];
            for (int n = 0; n < NS; n++) begin
                int b;
                if (reg_addr == 12'h100 + 4*(n/32) && reg_be[(n%32)/8] && reg_wdata[n%32]) m_en[n] = 1;
                if (reg_addr == 12'h180 + 4*(n/32) && reg_be[(n%32)/8] && reg_wdata[n%32]) m_en[n] = 0;
                if (reg_addr == 12'h400 + 4*(n/4) && reg_be[n%4]) m_prio[n] = reg_wdata[8*(n%4) +: 8];
                if (n >= 32 && reg_addr == 12'h800 + 4*(n/4) && reg_be[n%4]) m_tgt[n] = reg_wdata[8*(n%4) +: 2];
                b = 2*(n%16)+1;
                if (reg_addr == 12'hC00 + 4*(n/16) && reg_be[b/8]) m_edge[n] = reg_wdata[b];
            end
        end
    endtask

    task automatic check_all(string tag);
        bit v; int id; int p;
        for (int c = 0; c < NC; c++) begin
            exp_offer(c, v, id, p);
            n_cmp++;
            if (offer_valid[c] !== v || (v && (offer_id[c] !== 6'(id) || offer_prio[c] !== 8'(p)))) begin
                n_bad++;
                $display("FAIL %s core%0d: got v=%0b id=%0d p=%0d, expected v=%0b id=%0d p=%0d",
                         tag, c, offer_valid[c], offer_id[c], offer_prio[c], v, id, p);
            end
        end
    endtask

    // one clock: inputs already driven just after a falling edge
    task automatic tick();
        model_next();
        @(posedge clk);
        @(negedge clk);
        check_all("R10 model");
    endtask

    task automatic wr(bit [11:0] a, bit [3:0] be, bit [31:0] d);
        reg_wr = 1; reg_addr = a; reg_be = be; reg_wdata = d;
        tick();
        reg_wr = 0;
    endtask

    task automatic rd(bit [11:0] a, bit [31:0] expv, bit use_exp, string tag);
        bit [31:0] e;
        reg_addr = a;
        #1;
        e = use_exp ? expv : mrd(a);
        n_cmp++;
        if (reg_rdata !== e) begin
            n_bad++;
            $display("FAIL %s read 0x%03h: got 0x%08h expected 0x%08h", tag, a, reg_rdata, e);
        end
    endtask

    task automatic chk_offer(int c, bit v, int id, string tag);
        n_cmp++;
        if (offer_valid[c] !== v || (v && offer_id[c] !== 6'(id))) begin
            n_bad++;
            $display("FAIL %s core%0d: got v=%0b id=%0d expected v=%0b id=%0d",
                     tag, c, offer_valid[c], offer_id[c], v, id);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL R11 watchdog: got hang, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(20240611);
        for (int n = 0; n < NS; n++) begin
            m_en[n] = 0; m_prio[n] = 0; m_tgt[n] = 0; m_edge[n] = 0;
            m_pe[n] = 0; m_q[n] = 0; m_act[n] = 0;
        end
        m_den = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // reset state (R4, R1)
        check_all("R1 reset");
        rd(12'h400, 32'h0, 1, "R4 reset prio");
        rd(12'h43C, 32'h0, 1, "R4 reset prio last");
        rd(12'h000, 32'h0, 1, "R1 reset ctrl");
        rd(12'h100, 32'h0, 1, "R2 reset enables");

        // R2 / R3 enable banks
        wr(12'h100, 4'hF, 32'h5);
        rd(12'h100, 32'h5, 1, "R2 set");
        wr(12'h100, 4'hF, 32'h2);
        rd(12'h100, 32'h7, 1, "R2 set accumulates");
        wr(12'h180, 4'hF, 32'h1);
        rd(12'h180, 32'h6, 1, "R3 clear");
        wr(12'h100, 4'hF, 32'h0);
        wr(12'h180, 4'hF, 32'h0);
        rd(12'h100, 32'h6, 1, "R2 R3 zero write no effect");

        // R4 byte lanes
        wr(12'h404, 4'b0100, 32'hCDAB_1234);
        rd(12'h404, 32'h00AB_0000, 1, "R4 lane write");

        // R6 private targets fixed
        wr(12'h800, 4'hF, 32'hFFFF_FFFF);
        rd(12'h800, 32'h0101_0101, 1, "R6 private core0");
        wr(12'h810, 4'hF, 32'h0);
        rd(12'h810, 32'h0202_0202, 1, "R6 private core1");

        // R5 shared targets
        wr(12'h820, 4'hF, 32'hFF03_0201);
        rd(12'h820, 32'h0303_0201, 1, "R5 target store");
        wr(12'h820, 4'b0001, 32'h0);
        rd(12'h820, 32'h0303_0200, 1, "R5 target lane");

        // R7 config field
        wr(12'hC08, 4'hF, 32'hFFFF_FFFF);
        rd(12'hC08, 32'hAAAA_AAAA, 1, "R7 odd bits only");

        // directed set-up: ids 40..43 to core 1, id 41 edge
        wr(12'h180, 4'hF, 32'hFFFF_FFFF);
        wr(12'h000, 4'hF, 32'h1);
        wr(12'h104, 4'hF, 32'h0000_0F00);
        wr(12'h828, 4'hF, 32'h0202_0202);
        wr(12'hC08, 4'hF, 32'h0008_0000);
        wr(12'h428, 4'hF, 32'h0303_0405);

        // R8 level
        irq[40] = 1; tick();
        chk_offer(1, 1, 40, "R8 level offered");
        chk_offer(0, 0, 0, "R8 other core idle");
        irq[40] = 0; tick();
        chk_offer(1, 0, 0, "R8 level withdrawn");

        // R9 edge
        irq[41] = 1; tick();
        irq[41] = 0; tick();
        chk_offer(1, 1, 41, "R9 edge sticky");
        tick();
        chk_offer(1, 1, 41, "R9 edge still pending");
        ack[1] = 1; tick(); ack[1] = 0;
        chk_offer(1, 0, 0, "R9 ack hides");
        eoi[1] = 1; eoi_id[1] = 6'd41; tick(); eoi[1] = 0;
        chk_offer(1, 0, 0, "R9 cleared by ack");

        // R10 tie and priority
        irq[42] = 1; irq[43] = 1; tick();
        chk_offer(1, 1, 42, "R10 tie lower id");
        wr(12'h428, 4'b1000, 32'h0200_0000);
        chk_offer(1, 1, 43, "R10 lower value wins");

        // R11 active / retire
        ack[1] = 1; tick(); ack[1] = 0;
        chk_offer(1, 1, 42, "R11 active skipped");
        tick(); tick();
        chk_offer(1, 1, 42, "R11 still skipped");
        eoi[1] = 1; eoi_id[1] = 6'd43; tick(); eoi[1] = 0;
        chk_offer(1, 1, 43, "R11 reoffered after eoi");

        // R1 global switch
        wr(12'h000, 4'hF, 32'h0);
        chk_offer(1, 0, 0, "R1 switched off");
        wr(12'h000, 4'hF, 32'h1);
        chk_offer(1, 1, 43, "R1 switched on");
        irq[42] = 0; irq[43] = 0; tick();

        // random configuration
        for (int w = 0; w < 16; w++) wr(12'h400 + 12'(4*w), 4'hF, $urandom & 32'h0303_0303);
        for (int w = 8; w < 16; w++) wr(12'h800 + 12'(4*w), 4'hF, $urandom & 32'h0303_0303);
        for (int w = 0; w < 4; w++) wr(12'hC00 + 12'(4*w), 4'hF, $urandom);
        wr(12'h100, 4'hF, $urandom);
        wr(12'h104, 4'hF, $urandom | 32'h00FF_0000);

        for (int i = 0; i < 4000; i++) begin
            bit v; int id; int p;
            for (int n = 0; n < NS; n++) if ($urandom % 40 == 0) irq[n] = ~irq[n];
            for (int c = 0; c < NC; c++) begin
                exp_offer(c, v, id, p);
                ack[c] = v && ($urandom % 3 == 0);
                eoi[c] = 0;
            end
            if ($urandom % 3 == 0) begin
                int n = $urandom % NS;
                if (m_act[n]) begin
                    int c = $urandom % NC;
                    eoi[c] = 1; eoi_id[c] = 6'(n);
                end
            end
            if ($urandom % 60 == 0) begin
                int r = $urandom % 5;
                bit [11:0] a;
                case (r)
                    0: a = 12'h100 + 12'(4*($urandom % 2));
                    1: a = 12'h180 + 12'(4*($urandom % 2));
                    2: a = 12'h400 + 12'(4*($urandom % 16));
                    3: a = 12'h800 + 12'(4*($urandom % 16));
                    default: a = 12'hC00 + 12'(4*($urandom % 4));
                endcase
                reg_wr = 1; reg_addr = a; reg_be = 4'($urandom); reg_wdata = $urandom & 32'h0303_0303;
            end
            tick();
            reg_wr = 0; ack = '0; eoi = '0;
            if (i % 7 == 0) begin
                int r = $urandom % 6;
                case (r)
                    0: rd(12'h000, 0, 0, "R1 random read");
                    1: rd(12'h100 + 12'(4*($urandom % 2)), 0, 0, "R2 random read");
                    2: rd(12'h180 + 12'(4*($urandom % 2)), 0, 0, "R3 random read");
                    3: rd(12'h400 + 12'(4*($urandom % 16)), 0, 0, "R4 random read");
                    4: rd(12'h800 + 12'(4*($urandom % 16)), 0, 0, "R5 R6 random read");
                    default: rd(12'hC00 + 12'(4*($urandom % 4)), 0, 0, "R7 random read");
                endcase
            end
        end

        done = 1;
        summary();
        $finish;
    end

endmodule